// File: doc/BRIEF.md
# Programmable Down-Counting Timer with Tick Source Selection and Prescaler

This block is one timer channel for a system bus. It counts down from a programmed interval and raises a level interrupt each time the count runs out. Time is measured in ticks, not in system clocks. A 2-bit field in the control register picks which of two asynchronous tick inputs feeds the counter: a slow low-speed oscillator tick or a fast main-oscillator tick. The chosen input is synchronised to the system clock and edge-detected. A power-of-two prescaler then divides the chosen tick stream.

Software programs the timer through a small register file. The interval register holds the reload value. The current count can be read back. An interrupt status register holds the sticky pending flag and a sticky error flag, both cleared by writing 1. Any write to the control register takes the new source and divide settings at once and restarts the prescaler phase. If the reload bit is set in that write, the counter is also loaded from the interval.

Top module: `src_prescale_timer`

## Requirements
- R1: After reset the control register reads 0x4 (fast source, divide by 1, timer disabled). The interval, count and status registers read 0, and `irq_o` is low.
- R2: A control write (offset 0x0) with bit 1 set loads the count from the interval register (offset 0x4) on the next cycle. Bit 1 always reads back as 0, and the interval register reads back the value written.
- R3: Control bits [3:2] select the tick source: 0 selects `slow_tick_i` and 1 selects `fast_tick_i`. Each rising edge of the selected input is one source tick, and edges on the input that is not selected have no effect on the count.
- R4: Source codes 2 and 3 produce no ticks. A control write with code 3 sets the sticky error flag, status bit 1. Writing 1 to status bit 1 clears it.
- R5: Control bits [6:4] hold an exponent n. With the timer enabled, the count changes once for every 2^n source ticks, for n from 0 to 7.
- R6: Any control write restarts the prescaler. The first prescaled tick after the write comes only after a further 2^n source ticks.
- R7: The count changes on a prescaled tick only while control bit 0 (enable) is 1. While enable is 0, source ticks leave the count unchanged.
- R8: On a prescaled tick with the count at 1 or 0, the count reloads from the interval and the pending flag (status bit 0) is set. On any other prescaled tick the count decrements by one. `irq_o` follows the pending flag.
- R9: The pending flag stays set until software writes 1 to status bit 0 (offset 0xC). Writing 0 to that bit leaves it set. If a set and a clear fall in the same cycle, the set wins.
- R10: Writes to the count register (offset 0x8) are ignored, and reads from unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick_i | input | 1 | Asynchronous low-speed oscillator tick; each rising edge is one tick |
| fast_tick_i | input | 1 | Asynchronous main-oscillator tick; each rising edge is one tick |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt, high while the pending flag is set |

## Verification
The hardest case to reach from the ports is the prescaler phase. A control write must discard a partly filled division, and at the largest divide the count must not move for 127 source ticks and then move on the 128th. The bench reaches this by sending exact numbers of isolated rising edges on the tick inputs. Each edge is held long enough to pass the synchroniser, and the bench reads the count after each group of edges. To test the restart, it rewrites the control register between two groups of edges without the reload bit, so the count keeps its value and only the prescaler phase is reset.

// File: rtl/spt_pkg.sv
// Package: shared types and constants for the source-select/prescaler timer.
// Assumes a 32-bit register bus with 4-bit byte offsets.
package spt_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 4;
    localparam int SRC_COUNT = 2;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFF_CTRL  = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_IVAL  = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 4'hC;

    // Control field positions
    localparam int B_EN     = 0;
    localparam int B_RELOAD = 1;
    localparam int B_SRC_LO = 2;
    localparam int B_PRE_LO = 4;

    // Status field positions
    localparam int B_PEND = 0;
    localparam int B_ERR  = 1;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'd0,
        SRC_FAST = 2'd1,
        SRC_PLL  = 2'd2,
        SRC_BAD  = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic [2:0] pre;
        src_sel_e   src;
        logic       en;
    } ctrl_t;

endpackage

// File: rtl/spt_tick_sel.sv
// Tick selector: synchronises each asynchronous tick input, turns each
// rising edge into a one-cycle pulse and forwards the pulse of the chosen
// source. Assumes each input level is held for more than SYNC_STAGES+1
// system clocks. Unsupported source codes give no ticks.
module spt_tick_sel
    import spt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_COUNT-1:0] tick_async,
    input  src_sel_e             src,
    output logic                 src_tick
);

    logic [SRC_COUNT-1:0] edge_pulse;

    genvar g;
    generate
        for (g = 0; g < SRC_COUNT; g++) begin : g_sync
            logic [SYNC_STAGES-1:0] sh_q;
            logic                   prev_q;

            // Shift the raw input through the synchroniser and keep the last level
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh_q   <= '0;
                    prev_q <= 1'b0;
                end else begin
                    sh_q   <= {sh_q[SYNC_STAGES-2:0], tick_async[g]};
                    prev_q <= sh_q[SYNC_STAGES-1];
                end
            end

            assign edge_pulse[g] = sh_q[SYNC_STAGES-1] & ~prev_q;
        end
    endgenerate

    // Route the pulse of the selected source; reserved codes give none
    always_comb begin
        case (src)
            SRC_SLOW: src_tick = edge_pulse[0];
            SRC_FAST: src_tick = edge_pulse[1];
            default:  src_tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/spt_prescale.sv
// Prescaler: free-running counter advanced by source ticks. Passes one tick
// out of every 2^exp_n. A restart clears the phase, and any tick in the
// restart cycle is dropped.
module spt_prescale #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick_in,
    input  logic [PRE_W-1:0] exp_n,
    output logic             tick_out
);

    localparam int DIV_W = (1 << PRE_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W:0]   one_sh;
    logic [DIV_W-1:0] mask;

    // Build the mask of the low exp_n bits
    always_comb begin
        one_sh = (DIV_W+1)'(1) << exp_n;
        mask   = DIV_W'(one_sh - (DIV_W+1)'(1));
    end

    assign tick_out = tick_in && !restart && ((div_q & mask) == mask);

    // Advance the phase counter on source ticks; clear it on restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div_q <= '0;
        end else if (tick_in) begin
            div_q <= div_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/spt_counter.sv
// Down counter: loads from the interval on request. On an enabled tick it
// decrements, or reloads and reports expiry when at 1 or 0. A load beats a tick.
module spt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] ival,
    input  logic             enable,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    logic [CNT_W-1:0] count_q;
    logic             at_end;

    assign at_end = (count_q <= CNT_W'(1));
    assign expire = enable && tick && !load && at_end;
    assign count  = count_q;

    // Update the count from a load, a reload at expiry or a decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= ival;
        end else if (enable && tick) begin
            if (at_end) begin
                count_q <= ival;
            end else begin
                count_q <= count_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/spt_regs.sv
// Register file: control, interval, read-only count view and W1C status.
// Produces the restart and load strobes from control writes. Holds the
// sticky pending and error flags; a set in the same cycle as a clear wins.
module spt_regs
    import spt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              expire,
    output ctrl_t             ctrl,
    output logic              restart,
    output logic              load,
    output logic [CNT_W-1:0]  ival,
    output logic              pending
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] ival_q;
    logic             pend_q;
    logic             err_q;
    logic             wr_ctrl;
    logic             wr_ival;
    logic             wr_stat;
    src_sel_e         new_src;

    assign wr_ctrl = wr && (addr == OFF_CTRL);
    assign wr_ival = wr && (addr == OFF_IVAL);
    assign wr_stat = wr && (addr == OFF_STAT);
    assign new_src = src_sel_e'(wdata[B_SRC_LO +: 2]);

    assign restart = wr_ctrl;
    assign load    = wr_ctrl && wdata[B_RELOAD];
    assign ctrl    = ctrl_q;
    assign ival    = ival_q;
    assign pending = pend_q;

    // Capture control fields; reload bit is a strobe and is not stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.en  <= 1'b0;
            ctrl_q.src <= SRC_FAST;
            ctrl_q.pre <= 3'd0;
        end else if (wr_ctrl) begin
            ctrl_q.en  <= wdata[B_EN];
            ctrl_q.src <= new_src;
            ctrl_q.pre <= wdata[B_PRE_LO +: 3];
        end
    end

    // Capture the interval value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ival_q <= '0;
        end else if (wr_ival) begin
            ival_q <= wdata[CNT_W-1:0];
        end
    end

    // Pending flag: set on expiry, cleared by writing 1, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (expire) begin
            pend_q <= 1'b1;
        end else if (wr_stat && wdata[B_PEND]) begin
            pend_q <= 1'b0;
        end
    end

    // Error flag: set when an undefined source code is written, W1C
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (wr_ctrl && new_src == SRC_BAD) begin
            err_q <= 1'b1;
        end else if (wr_stat && wdata[B_ERR]) begin
            err_q <= 1'b0;
        end
    end

    // Read mux; the reload bit and unmapped offsets read as zero
    always_comb begin
        rdata = '0;
        case (addr)
            OFF_CTRL: begin
                rdata[B_EN]          = ctrl_q.en;
                rdata[B_SRC_LO +: 2] = ctrl_q.src;
                rdata[B_PRE_LO +: 3] = ctrl_q.pre;
            end
            OFF_IVAL:  rdata = DATA_W'(ival_q);
            OFF_COUNT: rdata = DATA_W'(count);
            OFF_STAT: begin
                rdata[B_PEND] = pend_q;
                rdata[B_ERR]  = err_q;
            end
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/src_prescale_timer.sv
// Top: one timer channel. Tick selection, prescaler, down counter and
// register file wired together. Assumes CNT_W is at most 32.
module src_prescale_timer
    import spt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_tick_i,
    input  logic        fast_tick_i,
    input  logic        reg_wr_i,
    input  logic [3:0]  reg_addr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    output logic        irq_o
);

    localparam int PRE_W = 3;

    ctrl_t            ctrl;
    logic             restart;
    logic             load;
    logic [CNT_W-1:0] ival_q;
    logic [CNT_W-1:0] count_q;
    logic             expire;
    logic             src_tick;
    logic             presc_tick;
    logic             pending;
    src_sel_e         ctrl_src;
    logic             ctrl_en;

    assign ctrl_src = ctrl.src;
    assign ctrl_en  = ctrl.en;
    assign irq_o    = pending;

    spt_tick_sel #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_async ({fast_tick_i, slow_tick_i}),
        .src        (ctrl_src),
        .src_tick   (src_tick)
    );

    spt_prescale #(
        .PRE_W (PRE_W)
    ) u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .tick_in  (src_tick),
        .exp_n    (ctrl.pre),
        .tick_out (presc_tick)
    );

    spt_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .ival   (ival_q),
        .enable (ctrl_en),
        .tick   (presc_tick),
        .count  (count_q),
        .expire (expire)
    );

    spt_regs #(
        .CNT_W (CNT_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr_i),
        .addr    (reg_addr_i),
        .wdata   (reg_wdata_i),
        .rdata   (reg_rdata_o),
        .count   (count_q),
        .expire  (expire),
        .ctrl    (ctrl),
        .restart (restart),
        .load    (load),
        .ival    (ival_q),
        .pending (pending)
    );

endmodule

// File: rtl/spt_checker.sv
// Checker: temporal properties of the timer, bound into the top module.
module spt_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [3:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] ival,
    input logic             en,
    input logic [1:0]       src,
    input logic             presc_tick,
    input logic             irq
);

    logic ctrl_wr;
    logic stat_clr;
    assign ctrl_wr  = reg_wr && (reg_addr == 4'h0);
    assign stat_clr = reg_wr && (reg_addr == 4'hC) && reg_wdata[0];

    // R2: reload bit loads the count from the interval
    assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && reg_wdata[1]) |=> (count == $past(ival)));

    // R2: reload bit never reads back as 1
    assert_rbit_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 4'h0) |-> (reg_rdata[1] == 1'b0));

    // R4: reserved source codes produce no prescaled ticks
    assert_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        src[1] |-> !presc_tick);

    // R7: a disabled timer holds its count unless reloaded
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !ctrl_wr) |=> $stable(count));

    // R8: the count only steps down by one or takes the interval
    assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(count)) |-> ((count == $past(count) - CNT_W'(1)) || (count == $past(ival))));

    // R9: the interrupt stays high until a write-1 clear
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_clr) |=> irq);

endmodule

bind src_prescale_timer spt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr_i),
    .reg_addr   (reg_addr_i),
    .reg_wdata  (reg_wdata_i),
    .reg_rdata  (reg_rdata_o),
    .count      (count_q),
    .ival       (ival_q),
    .en         (ctrl_en),
    .src        (ctrl_src),
    .presc_tick (presc_tick),
    .irq        (irq_o)
);

// File: tb/src_prescale_timer_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module src_prescale_timer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick_i = 1'b0;
    logic        fast_tick_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [3:0]  reg_addr_i = 4'h0;
    logic [31:0] reg_wdata_i = 32'h0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    src_prescale_timer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_tick_i (slow_tick_i),
        .fast_tick_i (fast_tick_i),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_o       (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_i    = 1'b1;
        reg_addr_i  = a;
        reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i    = 1'b0;
        reg_wdata_i = 32'h0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    // One rising edge on the chosen input (0 slow, 1 fast), repeated n times
    task automatic pulse(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (which == 0) slow_tick_i = 1'b1; else fast_tick_i = 1'b1;
            repeat (4) @(negedge clk);
            if (which == 0) slow_tick_i = 1'b0; else fast_tick_i = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(4'h0, d); chk("R1 ctrl", d, 32'h4);
        rd(4'h4, d); chk("R1 interval", d, 32'h0);
        rd(4'h8, d); chk("R1 count", d, 32'h0);
        rd(4'hC, d); chk("R1 status", d, 32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_reload;
        logic [31:0] d;
        wr(4'h4, 32'd10);
        rd(4'h4, d); chk("R2 interval readback", d, 32'd10);
        wr(4'h0, 32'h6);
        rd(4'h8, d); chk("R2 reload", d, 32'd10);
        rd(4'h0, d); chk("R2 reload bit reads 0", d, 32'h4);
    endtask

    task automatic t_source;
        logic [31:0] d;
        wr(4'h0, 32'h5);
        pulse(1, 3);
        rd(4'h8, d); chk("R3 fast ticks", d, 32'd7);
        pulse(0, 2);
        rd(4'h8, d); chk("R3 slow ignored", d, 32'd7);
        wr(4'h0, 32'h1);
        pulse(0, 2);
        rd(4'h8, d); chk("R3 slow ticks", d, 32'd5);
        pulse(1, 1);
        rd(4'h8, d); chk("R3 fast ignored", d, 32'd5);
    endtask

    task automatic t_badsrc;
        logic [31:0] d;
        wr(4'h0, 32'h9);
        pulse(0, 1); pulse(1, 1);
        rd(4'h8, d); chk("R4 code 2 no ticks", d, 32'd5);
        rd(4'hC, d); chk("R4 code 2 no error", d, 32'h0);
        wr(4'h0, 32'hD);
        pulse(0, 1); pulse(1, 1);
        rd(4'h8, d); chk("R4 code 3 no ticks", d, 32'd5);
        rd(4'hC, d); chk("R4 error set", d, 32'h2);
        wr(4'hC, 32'h2);
        rd(4'hC, d); chk("R4 error cleared", d, 32'h0);
    endtask

    task automatic t_presc;
        logic [31:0] d;
        wr(4'h4, 32'd100);
        wr(4'h0, 32'h27);
        pulse(1, 3);
        rd(4'h8, d); chk("R5 div4 before", d, 32'd100);
        pulse(1, 1);
        rd(4'h8, d); chk("R5 div4 first", d, 32'd99);
        pulse(1, 8);
        rd(4'h8, d); chk("R5 div4 more", d, 32'd97);
        wr(4'h0, 32'h77);
        pulse(1, 127);
        rd(4'h8, d); chk("R5 div128 before", d, 32'd100);
        pulse(1, 1);
        rd(4'h8, d); chk("R5 div128 first", d, 32'd99);
    endtask

    task automatic t_restart;
        logic [31:0] d;
        wr(4'h0, 32'h27);
        pulse(1, 2);
        wr(4'h0, 32'h25);
        rd(4'h8, d); chk("R6 no reload", d, 32'd100);
        pulse(1, 3);
        rd(4'h8, d); chk("R6 phase restarted", d, 32'd100);
        pulse(1, 1);
        rd(4'h8, d); chk("R6 full period", d, 32'd99);
    endtask

    task automatic t_enable;
        logic [31:0] d;
        wr(4'h0, 32'h4);
        pulse(1, 3);
        rd(4'h8, d); chk("R7 disabled hold", d, 32'd99);
    endtask

    task automatic t_expire;
        logic [31:0] d;
        wr(4'h4, 32'd3);
        wr(4'h0, 32'h7);
        pulse(1, 2);
        rd(4'h8, d); chk("R8 count 1", d, 32'd1);
        chk("R8 irq low", {31'h0, irq_o}, 32'h0);
        pulse(1, 1);
        rd(4'h8, d); chk("R8 reload at end", d, 32'd3);
        chk("R8 irq high", {31'h0, irq_o}, 32'h1);
        rd(4'hC, d); chk("R8 pending", d, 32'h1);
        pulse(1, 3);
        chk("R9 irq held", {31'h0, irq_o}, 32'h1);
        wr(4'hC, 32'h0);
        chk("R9 write 0 no clear", {31'h0, irq_o}, 32'h1);
        wr(4'hC, 32'h1);
        chk("R9 cleared", {31'h0, irq_o}, 32'h0);
        wr(4'h4, 32'd0);
        wr(4'h0, 32'h7);
        pulse(1, 1);
        rd(4'h8, d); chk("R8 zero interval count", d, 32'd0);
        chk("R8 zero interval irq", {31'h0, irq_o}, 32'h1);
        wr(4'hC, 32'h1);
    endtask

    task automatic t_readonly;
        logic [31:0] d;
        wr(4'h0, 32'h4);
        rd(4'h8, d);
        wr(4'h8, 32'h55);
        rd(4'h8, d); chk("R10 count read-only", d, 32'd0);
        rd(4'h2, d); chk("R10 unmapped", d, 32'h0);
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reload();
        t_source();
        t_badsrc();
        t_presc();
        t_restart();
        t_enable();
        t_expire();
        t_readonly();
        done = 1'b1;
        finish_up();
    end

endmodule